// File: doc/BRIEF.md
# Real-Time Clock Once-per-Second Update Sequencer

This block keeps the calendar time of a real-time clock: seconds, minutes, hours, day of week, day of month, month and two-digit year. A divider counts reference-clock ticks, which arrive as a one-cycle enable, and advances the whole time bank once per second with full carry handling. Month lengths and four-year leap years are applied.

A host reads the time registers at any moment. It needs a warning before they change. For this, a busy flag rises a fixed number of reference ticks before each advance. It stays high through an update window that follows the advance. When the window closes, a one-cycle done strobe is raised.

Counting can be BCD or plain binary. Hours can be 24-hour or 12-hour with a PM flag. While a hold input is set, the divider is kept at zero and nothing advances, so software can load the time through a byte-wide write port.

Top module: `rtc_update_unit`

## Requirements
- R1: After reset the time bank holds seconds 0, minutes 0, hours 0, day of week 1, day of month 1, month 1 and year 0, with busy_o and upd_done_o low.
- R2: busy_o rises on the reference tick that comes LEAD_TICKS ticks before the second-boundary tick. The time registers change on the boundary tick, which is the TICKS_PER_SEC-th tick counted from the divider's zero state.
- R3: busy_o stays high for WINDOW_TICKS ticks after the boundary tick. At the edge where it falls, upd_done_o is high for exactly one clock cycle.
- R4: While busy_o is low and no write is made, the time registers do not change.
- R5: While hold_set is high, the divider is held at zero: busy_o and upd_done_o stay low and the time does not advance. After hold_set clears, the first advance comes on the TICKS_PER_SEC-th tick.
- R6: A write stores wr_data at wr_addr. The addresses are seconds 0, minutes 2, hours 4, day of week 6, day of month 7, month 8 and year 9. A write to any other address changes nothing. A write on the boundary cycle wins over the advance for the register it addresses.
- R7: With bin_mode low, every byte holds two BCD digits, tens in bits 7:4 and ones in bits 3:0. With bin_mode high, every byte holds a plain binary value. Seconds and minutes wrap from 59 to 0 and carry.
- R8: With hr24_mode high, hours run 0 to 23. With it low, bit 7 of the hours byte flags PM and bits 6:0 hold 1 to 12. 11 PM advances to 12 AM and carries into the date, and 11 AM advances to 12 PM.
- R9: The day of week runs 1 to 7 and steps on every day carry, wrapping from 7 to 1.
- R10: The day of month wraps after 30 days in months 4, 6, 9 and 11, after 31 days in the other months, and in month 2 after 29 days when the year is a multiple of 4 and after 28 days otherwise. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable per reference-clock period |
| hold_set | input | 1 | Freeze the divider and all updates while the time is loaded |
| bin_mode | input | 1 | 1 = binary counting, 0 = BCD counting |
| hr24_mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour hours with PM in bit 7 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week |
| dom_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year |
| busy_o | output | 1 | Update in progress |
| upd_done_o | output | 1 | One-cycle strobe at the end of the update window |

## Verification
The assertions check the host-facing contract on every cycle. The time never moves unless busy was high on the cycle before or a write came in. Hold keeps busy, the strobe and the time quiet. The done strobe lasts one cycle and only closes a busy interval. The exact lead and window lengths, the carry rules for each calendar field, the BCD and 12-hour encodings, and write precedence on the boundary cycle can only be shown by the bench. It loads times next to each rollover and compares every output against its reference model on every clock, with the reference ticks both dense and sparse.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  // number of time fields held in the bank
  localparam int NF = 7;

  // field slots inside the bank
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DOM  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef logic [NF-1:0][7:0] tbank_t;

  // host address of each slot
  function automatic logic [3:0] fld_addr(input int idx);
    case (idx)
      F_SEC:   return 4'd0;
      F_MIN:   return 4'd2;
      F_HOUR:  return 4'd4;
      F_DOW:   return 4'd6;
      F_DOM:   return 4'd7;
      F_MON:   return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  // reset value of each slot: the day-based fields count from one
  function automatic logic [7:0] fld_rst(input int idx);
    return (idx == F_DOW || idx == F_DOM || idx == F_MON) ? 8'd1 : 8'd0;
  endfunction

  // stored byte -> binary value
  function automatic logic [6:0] dec(input logic [7:0] r, input logic bin);
    return bin ? r[6:0] : (7'(r[7:4]) * 7'd10 + 7'(r[3:0]));
  endfunction

  // binary value -> stored byte
  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] days_in(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                      return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LEAD_TICKS    = 8,
  parameter int WINDOW_TICKS  = 65
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic hold_i,
  output logic boundary_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam int WW = $clog2(WINDOW_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] RISE = CW'(TICKS_PER_SEC - 1 - LEAD_TICKS);
  localparam logic [WW-1:0] WLEN = WW'(WINDOW_TICKS);

  logic [CW-1:0] cnt_q;
  logic [WW-1:0] win_q;
  logic          busy_q;
  logic          done_q;

  assign boundary_o = tick_i && !hold_i && (cnt_q == LAST);
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q  <= '0;
      win_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        if (cnt_q == RISE) busy_q <= 1'b1;
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          win_q <= WLEN;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (win_q != '0) begin
            win_q <= win_q - 1'b1;
            if (win_q == WW'(1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_upd_next.sv
module rtc_upd_next
  import rtc_upd_pkg::*;
(
  input  tbank_t cur_i,
  input  logic   bin_i,
  input  logic   h24_i,
  output tbank_t nxt_o
);
  logic [6:0] s, m, h, w, d, mo, y, hraw;
  logic [6:0] ns, nm, nh, nw, nd, nmo, ny;
  logic       pm;

  always_comb begin
    s    = dec(cur_i[F_SEC], bin_i);
    m    = dec(cur_i[F_MIN], bin_i);
    w    = dec(cur_i[F_DOW], bin_i);
    d    = dec(cur_i[F_DOM], bin_i);
    mo   = dec(cur_i[F_MON], bin_i);
    y    = dec(cur_i[F_YEAR], bin_i);
    pm   = cur_i[F_HOUR][7];
    hraw = dec({1'b0, cur_i[F_HOUR][6:0]}, bin_i);
    if (h24_i)              h = hraw;
    else if (hraw == 7'd12) h = pm ? 7'd12 : 7'd0;
    else                    h = pm ? hraw + 7'd12 : hraw;

    ns = s; nm = m; nh = h; nw = w; nd = d; nmo = mo; ny = y;
    if (s < 7'd59) ns = s + 7'd1;
    else begin
      ns = 7'd0;
      if (m < 7'd59) nm = m + 7'd1;
      else begin
        nm = 7'd0;
        if (h < 7'd23) nh = h + 7'd1;
        else begin
          nh = 7'd0;
          nw = (w >= 7'd7) ? 7'd1 : w + 7'd1;
          if (d < days_in(mo, y)) nd = d + 7'd1;
          else begin
            nd = 7'd1;
            if (mo < 7'd12) nmo = mo + 7'd1;
            else begin
              nmo = 7'd1;
              ny  = (y >= 7'd99) ? 7'd0 : y + 7'd1;
            end
          end
        end
      end
    end

    nxt_o[F_SEC]  = enc(ns, bin_i);
    nxt_o[F_MIN]  = enc(nm, bin_i);
    nxt_o[F_DOW]  = enc(nw, bin_i);
    nxt_o[F_DOM]  = enc(nd, bin_i);
    nxt_o[F_MON]  = enc(nmo, bin_i);
    nxt_o[F_YEAR] = enc(ny, bin_i);
    if (h24_i)             nxt_o[F_HOUR] = enc(nh, bin_i);
    else if (nh == 7'd0)   nxt_o[F_HOUR] = enc(7'd12, bin_i);
    else if (nh < 7'd12)   nxt_o[F_HOUR] = enc(nh, bin_i);
    else if (nh == 7'd12)  nxt_o[F_HOUR] = enc(7'd12, bin_i) | 8'h80;
    else                   nxt_o[F_HOUR] = enc(nh - 7'd12, bin_i) | 8'h80;
  end
endmodule

// File: rtl/rtc_upd_regs.sv
module rtc_upd_regs
  import rtc_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       adv_i,
  input  tbank_t     nxt_i,
  output tbank_t     time_o
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam logic [3:0] ADDR = fld_addr(i);
    localparam logic [7:0] RVAL = fld_rst(i);
    logic [7:0] r_q;

    always_ff @(posedge clk) begin
      if (rst)                            r_q <= RVAL;
      else if (wr_en && wr_addr == ADDR)  r_q <= wr_data;
      else if (adv_i)                     r_q <= nxt_i[i];
    end

    assign time_o[i] = r_q;
  end
endmodule

// File: rtl/rtc_update_unit.sv
module rtc_update_unit
  import rtc_upd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LEAD_TICKS    = 8,
  parameter int WINDOW_TICKS  = 65
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       hold_set,
  input  logic       bin_mode,
  input  logic       hr24_mode,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] dom_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       busy_o,
  output logic       upd_done_o
);
  tbank_t bank, bank_nxt;
  logic   boundary;

  rtc_upd_seq #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .LEAD_TICKS   (LEAD_TICKS),
    .WINDOW_TICKS (WINDOW_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (ref_tick),
    .hold_i    (hold_set),
    .boundary_o(boundary),
    .busy_o    (busy_o),
    .done_o    (upd_done_o)
  );

  rtc_upd_next u_next (
    .cur_i(bank),
    .bin_i(bin_mode),
    .h24_i(hr24_mode),
    .nxt_o(bank_nxt)
  );

  rtc_upd_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .adv_i  (boundary),
    .nxt_i  (bank_nxt),
    .time_o (bank)
  );

  assign sec_o  = bank[F_SEC];
  assign min_o  = bank[F_MIN];
  assign hour_o = bank[F_HOUR];
  assign dow_o  = bank[F_DOW];
  assign dom_o  = bank[F_DOM];
  assign mon_o  = bank[F_MON];
  assign year_o = bank[F_YEAR];
endmodule

// File: rtl/rtc_update_unit_chk.sv
module rtc_update_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        hold_set,
  input logic        wr_en,
  input logic        busy_o,
  input logic        upd_done_o,
  input logic [55:0] tvec
);
  assert_idle_no_change_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !wr_en) |=> $stable(tvec));

  assert_change_needs_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(tvec) && !$past(wr_en)) |-> $past(busy_o));

  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    hold_set |=> (!busy_o && !upd_done_o));

  assert_hold_freezes_R5: assert property (@(posedge clk) disable iff (rst)
    (hold_set && !wr_en) |=> $stable(tvec));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    upd_done_o |=> !upd_done_o);

  assert_done_closes_busy_R3: assert property (@(posedge clk) disable iff (rst)
    upd_done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind rtc_update_unit rtc_update_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .hold_set  (hold_set),
  .wr_en     (wr_en),
  .busy_o    (busy_o),
  .upd_done_o(upd_done_o),
  .tvec      ({sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o})
);

// File: tb/rtc_update_unit_bench.sv
module rtc_update_unit_bench;
  localparam int TPS  = 40;
  localparam int LEAD = 5;
  localparam int WIN  = 6;

  logic clk = 1'b0, rst = 1'b1, ref_tick = 1'b0, hold_set = 1'b0;
  logic bin_mode = 1'b0, hr24_mode = 1'b1, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o;
  logic busy_o, upd_done_o;

  int checks = 0, fails = 0, tick_per = 1, cyc = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  rtc_update_unit #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD), .WINDOW_TICKS(WIN)) u_rtc_update_unit (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .hold_set(hold_set),
    .bin_mode(bin_mode), .hr24_mode(hr24_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .dom_o(dom_o), .mon_o(mon_o), .year_o(year_o),
    .busy_o(busy_o), .upd_done_o(upd_done_o)
  );

  always @(negedge clk) begin
    cyc++;
    ref_tick = (cyc % tick_per) == 0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int mb[7];
  int m_cnt, m_win;
  bit m_busy, m_done;

  function automatic int bdec(int b, bit bn);
    return bn ? b : (b / 16) * 10 + b % 16;
  endfunction
  function automatic int benc(int v, bit bn);
    return bn ? v : (v / 10) * 16 + v % 10;
  endfunction
  function automatic int to24(int b, bit bn, bit h24m);
    if (h24m) return bdec(b, bn);
    return bdec(b % 128, bn) % 12 + ((b >= 128) ? 12 : 0);
  endfunction
  function automatic int from24(int h, bit bn, bit h24m);
    int v;
    if (h24m) return benc(h, bn);
    v = h % 12;
    if (v == 0) v = 12;
    return benc(v, bn) + ((h >= 12) ? 128 : 0);
  endfunction
  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic int slot(logic [3:0] a);
    case (a)
      4'd0: return 0;
      4'd2: return 1;
      4'd4: return 2;
      4'd6: return 3;
      4'd7: return 4;
      4'd8: return 5;
      4'd9: return 6;
      default: return -1;
    endcase
  endfunction

  task automatic model_step();
    int s, mi, h, w, d, mo, y;
    s  = bdec(mb[0], bin_mode) + 1;
    mi = bdec(mb[1], bin_mode);
    h  = to24(mb[2], bin_mode, hr24_mode);
    w  = bdec(mb[3], bin_mode);
    d  = bdec(mb[4], bin_mode);
    mo = bdec(mb[5], bin_mode);
    y  = bdec(mb[6], bin_mode);
    if (s == 60) begin s = 0; mi++; end
    if (mi == 60) begin mi = 0; h++; end
    if (h == 24) begin
      h = 0; w = w % 7 + 1; d++;
      if (d > mlen(mo, y)) begin d = 1; mo++; end
      if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
    end
    mb[0] = benc(s, bin_mode);  mb[1] = benc(mi, bin_mode);
    mb[2] = from24(h, bin_mode, hr24_mode);
    mb[3] = benc(w, bin_mode);  mb[4] = benc(d, bin_mode);
    mb[5] = benc(mo, bin_mode); mb[6] = benc(y, bin_mode);
  endtask

  always @(posedge clk) begin
    bit bnd;
    int k;
    bnd = 0;
    if (rst) begin
      m_cnt = 0; m_win = 0; m_busy = 0; m_done = 0;
      mb = '{0, 0, 0, 1, 1, 1, 0};
    end else begin
      m_done = 0;
      if (hold_set) begin
        m_cnt = 0; m_win = 0; m_busy = 0;
      end else if (ref_tick) begin
        if (m_cnt == TPS - 1 - LEAD) m_busy = 1;
        if (m_cnt == TPS - 1) begin
          m_cnt = 0; m_win = WIN; bnd = 1;
        end else begin
          m_cnt++;
          if (m_win > 0) begin
            m_win--;
            if (m_win == 0) begin m_busy = 0; m_done = 1; end
          end
        end
      end
      if (bnd) model_step();
      if (wr_en) begin
        k = slot(wr_addr);
        if (k >= 0) mb[k] = int'(wr_data);
      end
    end
    #2;
    check(cur_req, sec_o,  mb[0], "sec");
    check(cur_req, min_o,  mb[1], "min");
    check(cur_req, hour_o, mb[2], "hour");
    check(cur_req, dow_o,  mb[3], "dow");
    check(cur_req, dom_o,  mb[4], "dom");
    check(cur_req, mon_o,  mb[5], "mon");
    check(cur_req, year_o, mb[6], "year");
    check("R2", busy_o, m_busy, "busy");
    check("R3", upd_done_o, m_done, "done");
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [3:0] a, logic [7:0] dt);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = dt;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] w,
                          logic [7:0] d, logic [7:0] mo, logic [7:0] y);
    @(negedge clk);
    hold_set = 1'b1;
    wr(0, s); wr(2, mi); wr(4, h); wr(6, w); wr(7, d); wr(8, mo); wr(9, y);
  endtask

  task automatic go();
    @(negedge clk);
    hold_set = 1'b0;
  endtask

  task automatic wait_done(int n);
    repeat (n) begin
      do @(negedge clk); while (!upd_done_o);
    end
  endtask

  task automatic measure(output int lead, output int hi, output bit dfall);
    logic [7:0] s0;
    do begin @(posedge clk); #2; end while (busy_o);
    do begin @(posedge clk); #2; end while (!busy_o);
    s0 = sec_o; lead = 0; hi = 0;
    do begin
      @(posedge clk); #2;
      hi++;
      if (lead == 0 && sec_o != s0) lead = hi;
    end while (busy_o);
    dfall = upd_done_o;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int lead, hi, n;
    bit dfall, seen_done;
    logic [7:0] s0;
    logic [55:0] snap;

    repeat (4) @(negedge clk);
    cur_req = "R1";
    check("R1", {sec_o, min_o, hour_o}, 24'h0, "reset time");
    check("R1", {dow_o, dom_o, mon_o, year_o}, 32'h01010100, "reset date");
    check("R1", {busy_o, upd_done_o}, 2'b00, "reset flags");
    rst = 1'b0;

    // R4: idle, time holds
    cur_req = "R4";
    repeat (10) @(negedge clk);
    check("R4", sec_o, 8'h00, "idle seconds");

    // R2 / R3: lead and window with a tick every cycle
    cur_req = "R2";
    measure(lead, hi, dfall);
    check("R2", lead, LEAD, "busy lead cycles");
    check("R3", hi, LEAD + WIN, "busy high cycles");
    check("R3", dfall, 1, "done at busy fall");
    check("R7", sec_o, 8'h01, "first advance");

    // R10 / R9: year rollover in BCD, 24h
    cur_req = "R10";
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    go(); wait_done(2);
    check("R7", {sec_o, min_o, hour_o}, 24'h0, "midnight");
    check("R9", dow_o, 8'h01, "dow wrap");
    check("R10", {dom_o, mon_o, year_o}, 24'h010100, "new year");

    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    go(); wait_done(1);
    check("R10", {dom_o, mon_o}, 16'h2902, "leap Feb 29");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    go(); wait_done(1);
    check("R10", {dom_o, mon_o}, 16'h0103, "non-leap Mar 1");
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h21);
    go(); wait_done(1);
    check("R10", {dom_o, mon_o}, 16'h0105, "30-day month");

    // R8: 12-hour mode
    cur_req = "R8";
    @(negedge clk); hold_set = 1'b1; hr24_mode = 1'b0;
    set_time(8'h59, 8'h59, 8'h91, 8'h02, 8'h15, 8'h06, 8'h10);
    go(); wait_done(1);
    check("R8", hour_o, 8'h12, "11 PM -> 12 AM");
    check("R9", {dow_o, dom_o}, 16'h0316, "date carry");
    set_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h15, 8'h06, 8'h10);
    go(); wait_done(1);
    check("R8", hour_o, 8'h92, "11 AM -> 12 PM");
    check("R8", dom_o, 8'h15, "no date carry");

    // R7: binary counting
    cur_req = "R7";
    @(negedge clk); hold_set = 1'b1; hr24_mode = 1'b1; bin_mode = 1'b1;
    set_time(8'd59, 8'd59, 8'd23, 8'd4, 8'd28, 8'd2, 8'd1);
    go(); wait_done(1);
    check("R7", {sec_o, min_o, hour_o}, 24'h0, "binary wrap");
    check("R7", {dow_o, dom_o, mon_o}, 24'h050103, "binary date");

    // R5: hold cancels a pending update and restarts the divider
    cur_req = "R5";
    @(negedge clk); hold_set = 1'b1; bin_mode = 1'b0;
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    go();
    do begin @(posedge clk); #2; end while (!busy_o);
    @(negedge clk); hold_set = 1'b1;
    @(posedge clk); #2;
    check("R5", busy_o, 1'b0, "busy dropped by hold");
    s0 = sec_o; seen_done = 0;
    repeat (3 * TPS) begin
      @(negedge clk);
      if (upd_done_o || busy_o) seen_done = 1;
    end
    check("R5", sec_o, s0, "frozen seconds");
    check("R5", seen_done, 0, "no busy or done while held");
    @(negedge clk); hold_set = 1'b0;
    n = 0;
    do begin @(posedge clk); #2; n++; end while (sec_o == s0);
    check("R5", n, TPS, "cycles to first advance");
    check("R5", sec_o, 8'h11, "resumed value");

    // R6: ignored addresses and write precedence at the boundary
    cur_req = "R6";
    @(negedge clk); hold_set = 1'b1;
    snap = {sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o};
    wr(4'd1, 8'h77); wr(4'd10, 8'h55); wr(4'd15, 8'h44);
    @(negedge clk);
    check("R6", {sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o}, snap, "unmapped writes");
    go();
    do begin @(posedge clk); #2; end while (!busy_o);
    repeat (LEAD - 1) @(negedge clk);
    wr(4'd0, 8'h30);
    wait_done(1);
    check("R6", sec_o, 8'h30, "write wins at boundary");
    wait_done(1);
    check("R6", sec_o, 8'h31, "next advance");

    // R2 / R3 with sparse reference ticks
    cur_req = "R2";
    tick_per = 3;
    measure(lead, hi, dfall);
    check("R2", lead, 3 * LEAD, "sparse lead cycles");
    check("R3", hi, 3 * (LEAD + WIN), "sparse busy cycles");
    check("R3", dfall, 1, "sparse done");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule